// File: doc/BRIEF.md
# Registered Integer ALU with Immediate Operand Forms

This block is the execute stage of a 32-bit integer core. Each cycle it may take one operation: an operation code, the first source value, a second source value, a 16-bit immediate, a 5-bit shift immediate and the index of the destination register. The operation code chooses the function. It also chooses whether the second operand is the register value, or the 16-bit immediate widened in one of three ways. The functions are addition, subtraction, bitwise logic, shifts and rotates, set-on-compare, and multiplication that returns either half of the product.

The result is registered, together with a write enable and the destination index. The register file downstream commits the write when the enable is high. A write aimed at register 0 is suppressed, so r0 stays zero. An operation code outside the defined set raises an illegal-operation flag and writes nothing.

Top module: `alu_core`

## Requirements
- R1: A strobe on `in_valid` gives `out_valid` high for exactly one cycle, at the next rising clock edge, with `out_dest` equal to the strobed destination. Without a strobe, `out_result` and `out_dest` keep their values. Reset clears `out_valid`, `out_wen`, `out_illegal`, `out_result` and `out_dest`.
- R2: The register forms are: add (code 0) gives A+B, sub (1) gives A-B, and (2) gives A&B, or (3) gives A|B, xor (4) gives A^B, and nor (5) gives ~(A|B).
- R3: These immediate forms sign-extend the 16-bit immediate: add-immediate (6), multiply-immediate (14) and the signed compare immediates (ge 33, lt 34, ne 35, eq 36).
- R4: These immediate forms zero-extend the 16-bit immediate: and-immediate (7), or-immediate (8), xor-immediate (9) and the unsigned compare immediates (geu 37, ltu 38).
- R5: These high immediate forms place the 16-bit immediate in bits 31:16 with zeros in bits 15:0: and-high (10), or-high (11) and xor-high (12). The and-high form therefore clears the low half.
- R6: The variable shifts use only bits 4:0 of B: arithmetic right (18), logical right (19), left (20), rotate left (21) and rotate right (22). The immediate shifts use the 5-bit field and ignore B: arithmetic right (23), logical right (24), left (25) and rotate left (26).
- R7: The register compares write 1 when true and 0 otherwise: signed ge (27), signed lt (28), ne (29), eq (30), unsigned geu (31) and unsigned ltu (32).
- R8: Multiply (13) and multiply-immediate (14) return the low 32 bits of the product. The high forms return bits 63:32 of the 64-bit product: signed×signed (15), unsigned×unsigned (16), and signed A × unsigned B (17).
- R9: A legal operation with destination 0 leaves `out_wen` low but still presents its result. A legal operation with a non-zero destination raises `out_wen`.
- R10: Operation codes 39 to 63 raise `out_illegal` for one cycle, leave `out_wen` low and present a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 6 | Operation code |
| in_ra | input | 32 | First source value A |
| in_rb | input | 32 | Second source value B |
| in_imm | input | 16 | 16-bit immediate |
| in_shamt | input | 5 | Shift immediate |
| in_dest | input | 5 | Destination register index |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Registered result |
| out_wen | output | 1 | Destination write enable |
| out_dest | output | 5 | Registered destination index |
| out_illegal | output | 1 | Undefined operation code seen |

## Verification
Two functions can fall in the same cycle: the r0 discard and the illegal-code flag. Either can also coincide with a normal result being produced. The bench strobes a legal add aimed at r0 and checks that the sum still appears while the enable stays low. It then strobes an undefined code, once aimed at r0 and once at a non-zero register, and checks that the flag rises while no write is enabled. Back-to-back strobes check that two results in consecutive cycles each appear for exactly one cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OP_ADD     = 6'd0;
    localparam logic [OP_W-1:0] OP_SUB     = 6'd1;
    localparam logic [OP_W-1:0] OP_AND     = 6'd2;
    localparam logic [OP_W-1:0] OP_OR      = 6'd3;
    localparam logic [OP_W-1:0] OP_XOR     = 6'd4;
    localparam logic [OP_W-1:0] OP_NOR     = 6'd5;
    localparam logic [OP_W-1:0] OP_ADDI    = 6'd6;
    localparam logic [OP_W-1:0] OP_ANDI    = 6'd7;
    localparam logic [OP_W-1:0] OP_ORI     = 6'd8;
    localparam logic [OP_W-1:0] OP_XORI    = 6'd9;
    localparam logic [OP_W-1:0] OP_ANDHI   = 6'd10;
    localparam logic [OP_W-1:0] OP_ORHI    = 6'd11;
    localparam logic [OP_W-1:0] OP_XORHI   = 6'd12;
    localparam logic [OP_W-1:0] OP_MUL     = 6'd13;
    localparam logic [OP_W-1:0] OP_MULI    = 6'd14;
    localparam logic [OP_W-1:0] OP_MULHSS  = 6'd15;
    localparam logic [OP_W-1:0] OP_MULHUU  = 6'd16;
    localparam logic [OP_W-1:0] OP_MULHSU  = 6'd17;
    localparam logic [OP_W-1:0] OP_SRA     = 6'd18;
    localparam logic [OP_W-1:0] OP_SRL     = 6'd19;
    localparam logic [OP_W-1:0] OP_SLL     = 6'd20;
    localparam logic [OP_W-1:0] OP_ROL     = 6'd21;
    localparam logic [OP_W-1:0] OP_ROR     = 6'd22;
    localparam logic [OP_W-1:0] OP_SRAI    = 6'd23;
    localparam logic [OP_W-1:0] OP_SRLI    = 6'd24;
    localparam logic [OP_W-1:0] OP_SLLI    = 6'd25;
    localparam logic [OP_W-1:0] OP_ROLI    = 6'd26;
    localparam logic [OP_W-1:0] OP_CGE     = 6'd27;
    localparam logic [OP_W-1:0] OP_CLT     = 6'd28;
    localparam logic [OP_W-1:0] OP_CNE     = 6'd29;
    localparam logic [OP_W-1:0] OP_CEQ     = 6'd30;
    localparam logic [OP_W-1:0] OP_CGEU    = 6'd31;
    localparam logic [OP_W-1:0] OP_CLTU    = 6'd32;
    localparam logic [OP_W-1:0] OP_CGEI    = 6'd33;
    localparam logic [OP_W-1:0] OP_CLTI    = 6'd34;
    localparam logic [OP_W-1:0] OP_CNEI    = 6'd35;
    localparam logic [OP_W-1:0] OP_CEQI    = 6'd36;
    localparam logic [OP_W-1:0] OP_CGEUI   = 6'd37;
    localparam logic [OP_W-1:0] OP_CLTUI   = 6'd38;

    // Function class selected by the decoder
    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_MULLO, K_MULHSS, K_MULHUU, K_MULHSU,
        K_SRA, K_SRL, K_SLL, K_ROL, K_ROR, K_CMP
    } kind_e;

    // Source of the second operand
    typedef enum logic [2:0] {
        B_REG, B_SEXT, B_ZEXT, B_HIGH, B_SH5
    } bsel_e;

    // Compare predicate
    typedef enum logic [2:0] {
        C_GE, C_LT, C_NE, C_EQ, C_GEU, C_LTU
    } cmp_e;

    typedef struct packed {
        kind_e kind;
        bsel_e bsel;
        cmp_e  cmp;
        logic  legal;
    } dec_t;

    function automatic dec_t decode(input logic [OP_W-1:0] op);
        dec_t d;
        d.kind  = K_ADD;
        d.bsel  = B_REG;
        d.cmp   = C_EQ;
        d.legal = 1'b1;
        case (op)
            OP_ADD:    d.kind = K_ADD;
            OP_SUB:    d.kind = K_SUB;
            OP_AND:    d.kind = K_AND;
            OP_OR:     d.kind = K_OR;
            OP_XOR:    d.kind = K_XOR;
            OP_NOR:    d.kind = K_NOR;
            OP_ADDI:   begin d.kind = K_ADD;   d.bsel = B_SEXT; end
            OP_ANDI:   begin d.kind = K_AND;   d.bsel = B_ZEXT; end
            OP_ORI:    begin d.kind = K_OR;    d.bsel = B_ZEXT; end
            OP_XORI:   begin d.kind = K_XOR;   d.bsel = B_ZEXT; end
            OP_ANDHI:  begin d.kind = K_AND;   d.bsel = B_HIGH; end
            OP_ORHI:   begin d.kind = K_OR;    d.bsel = B_HIGH; end
            OP_XORHI:  begin d.kind = K_XOR;   d.bsel = B_HIGH; end
            OP_MUL:    d.kind = K_MULLO;
            OP_MULI:   begin d.kind = K_MULLO; d.bsel = B_SEXT; end
            OP_MULHSS: d.kind = K_MULHSS;
            OP_MULHUU: d.kind = K_MULHUU;
            OP_MULHSU: d.kind = K_MULHSU;
            OP_SRA:    d.kind = K_SRA;
            OP_SRL:    d.kind = K_SRL;
            OP_SLL:    d.kind = K_SLL;
            OP_ROL:    d.kind = K_ROL;
            OP_ROR:    d.kind = K_ROR;
            OP_SRAI:   begin d.kind = K_SRA;   d.bsel = B_SH5; end
            OP_SRLI:   begin d.kind = K_SRL;   d.bsel = B_SH5; end
            OP_SLLI:   begin d.kind = K_SLL;   d.bsel = B_SH5; end
            OP_ROLI:   begin d.kind = K_ROL;   d.bsel = B_SH5; end
            OP_CGE:    begin d.kind = K_CMP;   d.cmp = C_GE;  end
            OP_CLT:    begin d.kind = K_CMP;   d.cmp = C_LT;  end
            OP_CNE:    begin d.kind = K_CMP;   d.cmp = C_NE;  end
            OP_CEQ:    begin d.kind = K_CMP;   d.cmp = C_EQ;  end
            OP_CGEU:   begin d.kind = K_CMP;   d.cmp = C_GEU; end
            OP_CLTU:   begin d.kind = K_CMP;   d.cmp = C_LTU; end
            OP_CGEI:   begin d.kind = K_CMP;   d.cmp = C_GE;  d.bsel = B_SEXT; end
            OP_CLTI:   begin d.kind = K_CMP;   d.cmp = C_LT;  d.bsel = B_SEXT; end
            OP_CNEI:   begin d.kind = K_CMP;   d.cmp = C_NE;  d.bsel = B_SEXT; end
            OP_CEQI:   begin d.kind = K_CMP;   d.cmp = C_EQ;  d.bsel = B_SEXT; end
            OP_CGEUI:  begin d.kind = K_CMP;   d.cmp = C_GEU; d.bsel = B_ZEXT; end
            OP_CLTUI:  begin d.kind = K_CMP;   d.cmp = C_LTU; d.bsel = B_ZEXT; end
            default:   d.legal = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic is_compare(input logic [OP_W-1:0] op);
        return (op >= OP_CGE) && (op <= OP_CLTUI);
    endfunction

endpackage

// File: rtl/alu_operand.sv
module alu_operand
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = 5
) (
    input  bsel_e               bsel,
    input  logic [DATA_W-1:0]   rb,
    input  logic [IMM_W-1:0]    imm,
    input  logic [SH_W-1:0]     shamt,
    output logic [DATA_W-1:0]   opb
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        case (bsel)
            B_SEXT:  opb = {{PAD_W{imm[IMM_W-1]}}, imm};
            B_ZEXT:  opb = {{PAD_W{1'b0}}, imm};
            B_HIGH:  opb = {imm, {PAD_W{1'b0}}};
            B_SH5:   opb = {{(DATA_W-SH_W){1'b0}}, shamt};
            default: opb = rb;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  kind_e               kind,
    input  logic [DATA_W-1:0]   a,
    input  logic [SH_W-1:0]     amt,
    output logic [DATA_W-1:0]   y
);
    logic [DATA_W-1:0] left_part;
    logic [DATA_W-1:0] right_part;

    // Amount zero gives a complementary shift of DATA_W, which yields zero
    always_comb begin
        left_part  = a << amt;
        right_part = a >> amt;
        case (kind)
            K_SRA:   y = DATA_W'($signed(a) >>> amt);
            K_SRL:   y = right_part;
            K_ROL:   y = left_part  | (a >> (DATA_W - int'(amt)));
            K_ROR:   y = right_part | (a << (DATA_W - int'(amt)));
            default: y = left_part;
        endcase
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi_uu,
    output logic [DATA_W-1:0] hi_ss,
    output logic [DATA_W-1:0] hi_su
);
    logic [2*DATA_W-1:0] prod_uu;
    logic [DATA_W-1:0]   corr_a;
    logic [DATA_W-1:0]   corr_b;

    // One unsigned multiplier; signed high halves are derived by correction
    always_comb begin
        prod_uu = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        corr_a  = a[DATA_W-1] ? b : '0;
        corr_b  = b[DATA_W-1] ? a : '0;
        lo      = prod_uu[DATA_W-1:0];
        hi_uu   = prod_uu[2*DATA_W-1:DATA_W];
        hi_su   = hi_uu - corr_a;
        hi_ss   = hi_uu - corr_a - corr_b;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int REG_W  = 5,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_ra,
    input  logic [DATA_W-1:0] in_rb,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [SH_W-1:0]   in_shamt,
    input  logic [REG_W-1:0]  in_dest,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wen,
    output logic [REG_W-1:0]  out_dest,
    output logic              out_illegal
);
    dec_t              dec;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] sh_y;
    logic [DATA_W-1:0] m_lo, m_uu, m_ss, m_su;
    logic              cmp_true;
    logic [DATA_W-1:0] res;

    assign dec = decode(in_op);

    alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_operand (
        .bsel  (dec.bsel),
        .rb    (in_rb),
        .imm   (in_imm),
        .shamt (in_shamt),
        .opb   (opb)
    );

    alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .kind (dec.kind),
        .a    (in_ra),
        .amt  (opb[SH_W-1:0]),
        .y    (sh_y)
    );

    alu_mul #(.DATA_W(DATA_W)) u_mul (
        .a     (in_ra),
        .b     (opb),
        .lo    (m_lo),
        .hi_uu (m_uu),
        .hi_ss (m_ss),
        .hi_su (m_su)
    );

    always_comb begin
        case (dec.cmp)
            C_GE:    cmp_true = $signed(in_ra) >= $signed(opb);
            C_LT:    cmp_true = $signed(in_ra) <  $signed(opb);
            C_NE:    cmp_true = in_ra != opb;
            C_GEU:   cmp_true = in_ra >= opb;
            C_LTU:   cmp_true = in_ra <  opb;
            default: cmp_true = in_ra == opb;
        endcase
    end

    always_comb begin
        case (dec.kind)
            K_ADD:    res = in_ra + opb;
            K_SUB:    res = in_ra - opb;
            K_AND:    res = in_ra & opb;
            K_OR:     res = in_ra | opb;
            K_XOR:    res = in_ra ^ opb;
            K_NOR:    res = ~(in_ra | opb);
            K_MULLO:  res = m_lo;
            K_MULHSS: res = m_ss;
            K_MULHUU: res = m_uu;
            K_MULHSU: res = m_su;
            K_CMP:    res = {{(DATA_W-1){1'b0}}, cmp_true};
            default:  res = sh_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            out_dest    <= '0;
        end else begin
            out_valid   <= in_valid;
            out_wen     <= in_valid && dec.legal && (in_dest != '0);
            out_illegal <= in_valid && !dec.legal;
            if (in_valid) begin
                out_result <= dec.legal ? res : '0;
                out_dest   <= in_dest;
            end
        end
    end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [REG_W-1:0]  in_dest,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wen,
    input logic [REG_W-1:0]  out_dest,
    input logic              out_illegal
);
    // R1: strobe appears one cycle later, absence of strobe gives no valid
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r1_dest_capture: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_dest == $past(in_dest));
    a_r1_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result) && $stable(out_dest));

    // R7: compares produce only 0 or 1
    a_r7_cmp_boolean: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_compare(in_op)) |=> out_result[DATA_W-1:1] == '0);

    // R9: no write enable toward register 0
    a_r9_no_r0_write: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_dest != '0) && out_valid);

    // R10: illegal flag excludes a write
    a_r10_illegal_nowrite: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_wen, out_illegal}));
    a_r10_illegal_valid: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_dest     (in_dest),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_wen     (out_wen),
    .out_dest    (out_dest),
    .out_illegal (out_illegal)
);

// File: tb/test_alu_core.sv
module test_alu_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_op = '0;
    logic [31:0] in_ra = '0;
    logic [31:0] in_rb = '0;
    logic [15:0] in_imm = '0;
    logic [4:0]  in_shamt = '0;
    logic [4:0]  in_dest = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_wen;
    logic [4:0]  out_dest;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_core i_alu_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm), .in_shamt(in_shamt),
        .in_dest(in_dest), .out_valid(out_valid), .out_result(out_result),
        .out_wen(out_wen), .out_dest(out_dest), .out_illegal(out_illegal)
    );

    // {op, A, B, imm16, imm5, expected}
    localparam int NV = 39;
    localparam logic [122:0] VEC [NV] = '{
        {6'd0,  32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'h0000000C},
        {6'd1,  32'h00000003, 32'h00000005, 16'h0000, 5'd0,  32'hFFFFFFFE},
        {6'd2,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 5'd0,  32'hF000F000},
        {6'd3,  32'hF0F0F0F0, 32'h0F0F0000, 16'h0000, 5'd0,  32'hFFFFF0F0},
        {6'd4,  32'hFFFF0000, 32'h0F0F0F0F, 16'h0000, 5'd0,  32'hF0F00F0F},
        {6'd5,  32'hF0F0F0F0, 32'h0F0F0000, 16'h0000, 5'd0,  32'h00000F0F},
        {6'd6,  32'h0000000A, 32'h12345678, 16'hFFFF, 5'd0,  32'h00000009},
        {6'd7,  32'hFFFFFFFF, 32'h00000000, 16'h8001, 5'd0,  32'h00008001},
        {6'd8,  32'h00000000, 32'hFFFFFFFF, 16'h8000, 5'd0,  32'h00008000},
        {6'd9,  32'h0000FFFF, 32'h00000000, 16'hF0F0, 5'd0,  32'h00000F0F},
        {6'd10, 32'h12345678, 32'h00000000, 16'hFF00, 5'd0,  32'h12000000},
        {6'd11, 32'h00000001, 32'h00000000, 16'h8000, 5'd0,  32'h80000001},
        {6'd12, 32'hFFFFFFFF, 32'h00000000, 16'h0F0F, 5'd0,  32'hF0F0FFFF},
        {6'd13, 32'h00010000, 32'h00010001, 16'h0000, 5'd0,  32'h00010000},
        {6'd14, 32'h00000003, 32'h00000000, 16'hFFFE, 5'd0,  32'hFFFFFFFA},
        {6'd15, 32'h80000000, 32'h00000002, 16'h0000, 5'd0,  32'hFFFFFFFF},
        {6'd16, 32'h80000000, 32'h00000002, 16'h0000, 5'd0,  32'h00000001},
        {6'd17, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 5'd0,  32'hFFFFFFFF},
        {6'd18, 32'h80000000, 32'h00000024, 16'h0000, 5'd0,  32'hF8000000},
        {6'd19, 32'h80000000, 32'hFFFFFFE4, 16'h0000, 5'd0,  32'h08000000},
        {6'd20, 32'h00000001, 32'h0000003F, 16'h0000, 5'd0,  32'h80000000},
        {6'd21, 32'h80000001, 32'h00000001, 16'h0000, 5'd0,  32'h00000003},
        {6'd22, 32'h00000003, 32'h00000001, 16'h0000, 5'd0,  32'h80000001},
        {6'd23, 32'h80000000, 32'h00000000, 16'h0000, 5'd31, 32'hFFFFFFFF},
        {6'd24, 32'h80000000, 32'h00000005, 16'h0000, 5'd31, 32'h00000001},
        {6'd25, 32'h00000003, 32'h00000000, 16'h0000, 5'd4,  32'h00000030},
        {6'd26, 32'hF0000000, 32'h00000011, 16'h0000, 5'd4,  32'h0000000F},
        {6'd27, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000},
        {6'd28, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001},
        {6'd29, 32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000000},
        {6'd30, 32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000001},
        {6'd31, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001},
        {6'd32, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000},
        {6'd33, 32'h00000000, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001},
        {6'd34, 32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001},
        {6'd35, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000000},
        {6'd36, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001},
        {6'd37, 32'h0000FFFF, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001},
        {6'd38, 32'h00010000, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000000}
    };

    function automatic string req_of(input logic [5:0] op);
        if (op <= 6'd5)                        return "R2";
        if (op == 6'd6 || (op >= 6'd33 && op <= 6'd36)) return "R3";
        if (op == 6'd14)                       return "R3/R8";
        if ((op >= 6'd7 && op <= 6'd9) || op >= 6'd37) return "R4";
        if (op >= 6'd10 && op <= 6'd12)        return "R5";
        if (op >= 6'd13 && op <= 6'd17)        return "R8";
        if (op >= 6'd18 && op <= 6'd26)        return "R6";
        return "R7";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; outputs are sampled at the next falling edge
    task automatic issue(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh, input logic [4:0] dst);
        @(negedge clk);
        in_op = op; in_ra = a; in_rb = b; in_imm = imm; in_shamt = sh; in_dest = dst;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R1 reset wen", {31'b0, out_wen}, 32'd0);
        chk("R1 reset illegal", {31'b0, out_illegal}, 32'd0);
        chk("R1 reset result", out_result, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [5:0] vop;
            logic [4:0] vd;
            vop = VEC[i][122:117];
            vd  = 5'((i % 31) + 1);
            issue(vop, VEC[i][116:85], VEC[i][84:53], VEC[i][52:37], VEC[i][36:32], vd);
            chk(req_of(vop), out_result, VEC[i][31:0]);
            chk("R9 wen nonzero dest", {31'b0, out_wen}, 32'd1);
            chk("R1 dest", {27'b0, out_dest}, {27'b0, vd});
        end

        // R1: no strobe -> valid low, result held
        @(negedge clk);
        chk("R1 idle valid", {31'b0, out_valid}, 32'd0);
        chk("R1 idle hold", out_result, 32'd0);

        // R9: r0 destination, result still presented
        issue(6'd0, 32'd5, 32'd7, 16'h0, 5'd0, 5'd0);
        chk("R9 r0 wen", {31'b0, out_wen}, 32'd0);
        chk("R9 r0 result", out_result, 32'h0000000C);
        chk("R9 r0 valid", {31'b0, out_valid}, 32'd1);

        // R10: undefined codes
        issue(6'd39, 32'd1, 32'd1, 16'h0, 5'd0, 5'd5);
        chk("R10 illegal flag", {31'b0, out_illegal}, 32'd1);
        chk("R10 illegal wen", {31'b0, out_wen}, 32'd0);
        chk("R10 illegal result", out_result, 32'd0);
        issue(6'd63, 32'd1, 32'd1, 16'h0, 5'd0, 5'd0);
        chk("R10 illegal r0 flag", {31'b0, out_illegal}, 32'd1);
        chk("R10 illegal r0 wen", {31'b0, out_wen}, 32'd0);
        @(negedge clk);
        chk("R10 flag one cycle", {31'b0, out_illegal}, 32'd0);

        // R1: back-to-back strobes
        @(negedge clk);
        in_op = 6'd0; in_ra = 32'd100; in_rb = 32'd1; in_dest = 5'd3; in_valid = 1'b1;
        @(negedge clk);
        chk("R1 b2b first", out_result, 32'd101);
        in_op = 6'd1; in_ra = 32'd100; in_rb = 32'd1; in_dest = 5'd4;
        @(negedge clk);
        chk("R1 b2b second", out_result, 32'd99);
        chk("R1 b2b dest", {27'b0, out_dest}, 32'd4);
        chk("R1 b2b valid", {31'b0, out_valid}, 32'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 b2b end valid", {31'b0, out_valid}, 32'd0);
        chk("R1 b2b hold", out_result, 32'd99);

        // R6: zero rotate amount leaves value unchanged
        issue(6'd22, 32'h12345678, 32'h00000020, 16'h0, 5'd0, 5'd7);
        chk("R6 rotate by zero", out_result, 32'h12345678);

        done = 1'b1;
        summary();
    end
endmodule